// File: doc/BRIEF.md
# Programmable Video Sync Timing Generator

This block generates horizontal sync, vertical sync and a data-enable window for a video-mode display link. All timing comes from registers that software writes through a simple write port. Two free-running counters run while the block is enabled. The line counter steps through the pixels of one line. The frame counter steps through every pixel clock of the whole frame. Both counters start at zero on the first pixel of the sync pulse. Vertical timing is therefore written as flat pixel-clock counts, not as line numbers, and every vertical event is one compare against the frame counter.

Software writes into a shadow set. The working set is copied from the shadow set only at a frame boundary, and the enable bit is copied at the same moment. A disable written in the middle of a frame lets that frame finish. The block then stops in its idle state, where the syncs sit at their inactive levels. A one-cycle frame-start pulse marks pixel zero of every frame, so software can use it to confirm that a disable has taken effect.

Inside the active window the block passes the upstream pixel through. If upstream has no pixel ready, it drives a programmed recovery colour instead. Outside the window the pixel output is zero.

Top module: `vid_sync_gen`

## Requirements
- R1: While running, `hsync` is asserted during the first W pixels of every line and the line repeats every P pixels. P is register 0 bits [HW-1:0] and W is register 0 bits [16+HW-1:16].
- R2: While running, `vsync` is asserted while the frame pixel count is below the sync length (register 2), and the frame repeats every F pixels (register 1).
- R3: `de` and `pix_req` are asserted together. This happens exactly when the line count lies in [register 3 bits [HW-1:0], register 3 bits [16+HW-1:16]] and the frame count lies in [register 4 + skew, register 5 + skew], both bounds inclusive.
- R4: The skew value (register 6) shifts both vertical window bounds by its value in pixel clocks.
- R5: Register 7 bit 0 makes `hsync` active-low and bit 1 makes `vsync` active-low. When idle, each sync output sits at its inactive level, which equals its polarity bit.
- R6: Inside the window, `pix_out` is `pix_data` when `pix_valid` is high. Otherwise `underflow` is raised and `pix_out` is the register 8 colour (bits [CW-1:0]) when register 8 bit 31 is set, or zero when it is clear. Outside the window, `pix_out` is zero and `underflow` is low.
- R7: Writing 0 to register 9 bit 0 while running lets the current frame complete. The block goes idle on the cycle that would have been pixel zero of the next frame.
- R8: A register write made during a frame does not change that frame. It applies from the next frame onward.
- R9: `frame_pulse` is high for exactly one cycle, on pixel zero of each frame, and only while running.
- R10: After reset, the block is idle with all registers zero: syncs low, `de` low, `pix_out` zero and no frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register index (0..9) |
| wr_data | input | DW | Register write data |
| pix_valid | input | 1 | Upstream pixel available |
| pix_data | input | CW | Upstream pixel value |
| pix_req | output | 1 | Pixel request, follows data-enable |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data-enable window |
| pix_out | output | CW | Pixel to the link |
| underflow | output | 1 | Missing pixel inside the window |
| frame_pulse | output | 1 | One-cycle pulse on pixel zero of a frame |

## Verification
The bench sweeps every pixel of whole frames on a small 8x5 raster and computes the expected line and frame positions arithmetically. It looks for window edges that are off by one at either inclusive bound. A design with that fault would show `de` one pixel early or late. It writes the skew in mid-frame to catch two faults: a design that shifts only one vertical bound, and one that lets the new value into the current frame, which would leave a torn frame. It writes a disable at pixel 10 of a frame. A design that stops at once would cut that frame short, and one that never latches would keep the syncs toggling. With recovery switched off, an underflow must produce black and not a stale colour. The idle sync levels are checked with inverted polarity, where a design that forces zero while idle would be caught.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

  // Register indices of the write port
  typedef enum logic [3:0] {
    REG_HTIME  = 4'd0,  // [HW-1:0] line period, [16+HW-1:16] hsync width
    REG_FTOTAL = 4'd1,  // frame period in pixel clocks
    REG_VSLEN  = 4'd2,  // vsync length in pixel clocks
    REG_HWIN   = 4'd3,  // [HW-1:0] first active pixel, [16+HW-1:16] last
    REG_VFIRST = 4'd4,  // first active frame count (before skew)
    REG_VLAST  = 4'd5,  // last active frame count (before skew)
    REG_SKEW   = 4'd6,  // added to both vertical bounds
    REG_POL    = 4'd7,  // bit0 hsync low, bit1 vsync low
    REG_FILL   = 4'd8,  // [CW-1:0] colour, bit31 recovery enable
    REG_RUN    = 4'd9   // bit0 enable
  } vsg_reg_e;

  localparam int unsigned HI_LSB = 16;

endpackage

// File: rtl/vsg_regs.sv
module vsg_regs
  import vsg_pkg::*;
#(
  parameter int unsigned HW = 12,
  parameter int unsigned FW = 24,
  parameter int unsigned CW = 24,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [HW-1:0] s_hper,
  output logic [HW-1:0] s_hpw,
  output logic [FW-1:0] s_fper,
  output logic [FW-1:0] s_vlen,
  output logic [HW-1:0] s_hfirst,
  output logic [HW-1:0] s_hlast,
  output logic [FW-1:0] s_vfirst,
  output logic [FW-1:0] s_vlast,
  output logic [FW-1:0] s_skew,
  output logic          s_polh,
  output logic          s_polv,
  output logic          s_rec,
  output logic [CW-1:0] s_col,
  output logic          s_en
);

  localparam int unsigned HHI = HI_LSB + HW - 1;

  logic [HW-1:0] hper_d, hpw_d, hfirst_d, hlast_d;
  logic [FW-1:0] fper_d, vlen_d, vfirst_d, vlast_d, skew_d;
  logic          polh_d, polv_d, rec_d, en_d;
  logic [CW-1:0] col_d;
  logic          unused_wr_bits;

  function automatic logic hit(input logic [AW-1:0] a, input vsg_reg_e r);
    return a == AW'(r);
  endfunction

  assign unused_wr_bits = ^wr_data;

  always_comb begin
    hper_d   = s_hper;   hpw_d   = s_hpw;
    fper_d   = s_fper;   vlen_d  = s_vlen;
    hfirst_d = s_hfirst; hlast_d = s_hlast;
    vfirst_d = s_vfirst; vlast_d = s_vlast;
    skew_d   = s_skew;
    polh_d   = s_polh;   polv_d  = s_polv;
    rec_d    = s_rec;    col_d   = s_col;
    en_d     = s_en;
    if (wr_en) begin
      if (hit(wr_addr, REG_HTIME)) begin
        hper_d = wr_data[HW-1:0];
        hpw_d  = wr_data[HHI:HI_LSB];
      end
      if (hit(wr_addr, REG_FTOTAL)) fper_d = wr_data[FW-1:0];
      if (hit(wr_addr, REG_VSLEN))  vlen_d = wr_data[FW-1:0];
      if (hit(wr_addr, REG_HWIN)) begin
        hfirst_d = wr_data[HW-1:0];
        hlast_d  = wr_data[HHI:HI_LSB];
      end
      if (hit(wr_addr, REG_VFIRST)) vfirst_d = wr_data[FW-1:0];
      if (hit(wr_addr, REG_VLAST))  vlast_d  = wr_data[FW-1:0];
      if (hit(wr_addr, REG_SKEW))   skew_d   = wr_data[FW-1:0];
      if (hit(wr_addr, REG_POL)) begin
        polh_d = wr_data[0];
        polv_d = wr_data[1];
      end
      if (hit(wr_addr, REG_FILL)) begin
        col_d = wr_data[CW-1:0];
        rec_d = wr_data[DW-1];
      end
      if (hit(wr_addr, REG_RUN)) en_d = wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_hper   <= '0; s_hpw   <= '0;
      s_fper   <= '0; s_vlen  <= '0;
      s_hfirst <= '0; s_hlast <= '0;
      s_vfirst <= '0; s_vlast <= '0;
      s_skew   <= '0;
      s_polh   <= 1'b0; s_polv <= 1'b0;
      s_rec    <= 1'b0; s_col  <= '0;
      s_en     <= 1'b0;
    end else if (wr_en) begin
      s_hper   <= hper_d;   s_hpw   <= hpw_d;
      s_fper   <= fper_d;   s_vlen  <= vlen_d;
      s_hfirst <= hfirst_d; s_hlast <= hlast_d;
      s_vfirst <= vfirst_d; s_vlast <= vlast_d;
      s_skew   <= skew_d;
      s_polh   <= polh_d;   s_polv  <= polv_d;
      s_rec    <= rec_d;    s_col   <= col_d;
      s_en     <= en_d;
    end
  end

endmodule

// File: rtl/vsg_core.sv
module vsg_core #(
  parameter int unsigned HW = 12,
  parameter int unsigned FW = 24,
  parameter int unsigned CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] s_hper,
  input  logic [HW-1:0] s_hpw,
  input  logic [FW-1:0] s_fper,
  input  logic [FW-1:0] s_vlen,
  input  logic [HW-1:0] s_hfirst,
  input  logic [HW-1:0] s_hlast,
  input  logic [FW-1:0] s_vfirst,
  input  logic [FW-1:0] s_vlast,
  input  logic [FW-1:0] s_skew,
  input  logic          s_polh,
  input  logic          s_polv,
  input  logic          s_rec,
  input  logic [CW-1:0] s_col,
  input  logic          s_en,
  output logic          run,
  output logic [HW-1:0] hcnt,
  output logic [FW-1:0] fcnt,
  output logic [HW-1:0] w_hper,
  output logic [HW-1:0] w_hpw,
  output logic [FW-1:0] w_fper,
  output logic [FW-1:0] w_vlen,
  output logic [HW-1:0] w_hfirst,
  output logic [HW-1:0] w_hlast,
  output logic [FW-1:0] w_vfirst,
  output logic [FW-1:0] w_vlast,
  output logic [FW-1:0] w_skew,
  output logic          w_polh,
  output logic          w_polv,
  output logic          w_rec,
  output logic [CW-1:0] w_col
);

  logic          frame_end, cfg_ld, run_d;
  logic [HW-1:0] hcnt_d;
  logic [FW-1:0] fcnt_d;

  // The working set and the run state change only at a frame boundary;
  // while idle every cycle counts as one.
  assign frame_end = run && (fcnt == w_fper - 1'b1);
  assign cfg_ld    = !run || frame_end;

  always_comb begin
    run_d  = run;
    hcnt_d = hcnt;
    fcnt_d = fcnt;
    if (cfg_ld) begin
      run_d  = s_en;
      hcnt_d = '0;
      fcnt_d = '0;
    end else begin
      fcnt_d = fcnt + 1'b1;
      hcnt_d = (hcnt == w_hper - 1'b1) ? '0 : hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      hcnt <= '0;
      fcnt <= '0;
    end else begin
      run  <= run_d;
      hcnt <= hcnt_d;
      fcnt <= fcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_hper   <= '0; w_hpw   <= '0;
      w_fper   <= '0; w_vlen  <= '0;
      w_hfirst <= '0; w_hlast <= '0;
      w_vfirst <= '0; w_vlast <= '0;
      w_skew   <= '0;
      w_polh   <= 1'b0; w_polv <= 1'b0;
      w_rec    <= 1'b0; w_col  <= '0;
    end else if (cfg_ld) begin
      w_hper   <= s_hper;   w_hpw   <= s_hpw;
      w_fper   <= s_fper;   w_vlen  <= s_vlen;
      w_hfirst <= s_hfirst; w_hlast <= s_hlast;
      w_vfirst <= s_vfirst; w_vlast <= s_vlast;
      w_skew   <= s_skew;
      w_polh   <= s_polh;   w_polv  <= s_polv;
      w_rec    <= s_rec;    w_col   <= s_col;
    end
  end

endmodule

// File: rtl/vsg_window.sv
module vsg_window #(
  parameter int unsigned HW = 12,
  parameter int unsigned FW = 24,
  parameter int unsigned CW = 24
) (
  input  logic          run,
  input  logic [HW-1:0] hcnt,
  input  logic [FW-1:0] fcnt,
  input  logic [HW-1:0] w_hpw,
  input  logic [FW-1:0] w_vlen,
  input  logic [HW-1:0] w_hfirst,
  input  logic [HW-1:0] w_hlast,
  input  logic [FW-1:0] w_vfirst,
  input  logic [FW-1:0] w_vlast,
  input  logic [FW-1:0] w_skew,
  input  logic          w_polh,
  input  logic          w_polv,
  input  logic          w_rec,
  input  logic [CW-1:0] w_col,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pix_req,
  output logic [CW-1:0] pix_out,
  output logic          underflow,
  output logic          frame_pulse
);

  logic [FW-1:0] v_lo, v_hi;
  logic          h_act, v_act, h_in, v_in;

  assign v_lo  = w_vfirst + w_skew;
  assign v_hi  = w_vlast + w_skew;

  assign h_act = run && (hcnt < w_hpw);
  assign v_act = run && (fcnt < w_vlen);
  assign h_in  = (hcnt >= w_hfirst) && (hcnt <= w_hlast);
  assign v_in  = (fcnt >= v_lo) && (fcnt <= v_hi);

  assign hsync       = h_act ^ w_polh;
  assign vsync       = v_act ^ w_polv;
  assign de          = run && h_in && v_in;
  assign pix_req     = de;
  assign underflow   = de && !pix_valid;
  assign frame_pulse = run && (fcnt == '0);

  always_comb begin
    pix_out = '0;
    if (de) begin
      if (pix_valid)  pix_out = pix_data;
      else if (w_rec) pix_out = w_col;
    end
  end

endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen #(
  parameter int unsigned HW = 12,
  parameter int unsigned FW = 24,
  parameter int unsigned CW = 24,
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_data,
  output logic          pix_req,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pix_out,
  output logic          underflow,
  output logic          frame_pulse
);

  logic [HW-1:0] s_hper, s_hpw, s_hfirst, s_hlast;
  logic [FW-1:0] s_fper, s_vlen, s_vfirst, s_vlast, s_skew;
  logic          s_polh, s_polv, s_rec, s_en;
  logic [CW-1:0] s_col;

  logic          run;
  logic [HW-1:0] hcnt, w_hper, w_hpw, w_hfirst, w_hlast;
  logic [FW-1:0] fcnt, w_fper, w_vlen, w_vfirst, w_vlast, w_skew;
  logic          w_polh, w_polv, w_rec;
  logic [CW-1:0] w_col;

  vsg_regs #(.HW(HW), .FW(FW), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .s_hper(s_hper), .s_hpw(s_hpw), .s_fper(s_fper), .s_vlen(s_vlen),
    .s_hfirst(s_hfirst), .s_hlast(s_hlast),
    .s_vfirst(s_vfirst), .s_vlast(s_vlast), .s_skew(s_skew),
    .s_polh(s_polh), .s_polv(s_polv), .s_rec(s_rec), .s_col(s_col),
    .s_en(s_en)
  );

  vsg_core #(.HW(HW), .FW(FW), .CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n),
    .s_hper(s_hper), .s_hpw(s_hpw), .s_fper(s_fper), .s_vlen(s_vlen),
    .s_hfirst(s_hfirst), .s_hlast(s_hlast),
    .s_vfirst(s_vfirst), .s_vlast(s_vlast), .s_skew(s_skew),
    .s_polh(s_polh), .s_polv(s_polv), .s_rec(s_rec), .s_col(s_col),
    .s_en(s_en),
    .run(run), .hcnt(hcnt), .fcnt(fcnt),
    .w_hper(w_hper), .w_hpw(w_hpw), .w_fper(w_fper), .w_vlen(w_vlen),
    .w_hfirst(w_hfirst), .w_hlast(w_hlast),
    .w_vfirst(w_vfirst), .w_vlast(w_vlast), .w_skew(w_skew),
    .w_polh(w_polh), .w_polv(w_polv), .w_rec(w_rec), .w_col(w_col)
  );

  vsg_window #(.HW(HW), .FW(FW), .CW(CW)) u_win (
    .run(run), .hcnt(hcnt), .fcnt(fcnt),
    .w_hpw(w_hpw), .w_vlen(w_vlen),
    .w_hfirst(w_hfirst), .w_hlast(w_hlast),
    .w_vfirst(w_vfirst), .w_vlast(w_vlast), .w_skew(w_skew),
    .w_polh(w_polh), .w_polv(w_polv), .w_rec(w_rec), .w_col(w_col),
    .pix_valid(pix_valid), .pix_data(pix_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req),
    .pix_out(pix_out), .underflow(underflow), .frame_pulse(frame_pulse)
  );

endmodule

// File: rtl/vsg_checker.sv
module vsg_checker #(
  parameter int unsigned HW = 12,
  parameter int unsigned FW = 24,
  parameter int unsigned CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [HW-1:0] hcnt,
  input logic [FW-1:0] fcnt,
  input logic [HW-1:0] w_hper,
  input logic [FW-1:0] w_fper,
  input logic          w_polh,
  input logic          w_polv,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [CW-1:0] pix_out,
  input logic          underflow,
  input logic          frame_pulse
);

  assert_line_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && hcnt == '0 && fcnt != '0) |-> ($past(hcnt) == $past(w_hper) - 1'b1));

  assert_de_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> run);

  assert_idle_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (hsync == w_polh && vsync == w_polv && !de));

  assert_blank_black_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pix_out == '0 && !underflow));

  assert_stop_at_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(fcnt) == $past(w_fper) - 1'b1));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && fcnt != '0) |-> ($stable(w_hper) && $stable(w_fper)));

  assert_pulse_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> (run && hcnt == '0 && fcnt == '0));

endmodule

bind vid_sync_gen vsg_checker #(.HW(HW), .FW(FW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .hcnt(hcnt), .fcnt(fcnt),
  .w_hper(w_hper), .w_fper(w_fper), .w_polh(w_polh), .w_polv(w_polv),
  .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
  .underflow(underflow), .frame_pulse(frame_pulse)
);

// File: tb/tb_vid_sync_gen.sv
module tb_vid_sync_gen;

  localparam int unsigned HW = 12;
  localparam int unsigned FW = 24;
  localparam int unsigned CW = 24;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 32;

  logic          clk, rst_n, wr_en, pix_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] pix_data, pix_out;
  logic          pix_req, hsync, vsync, de, underflow, frame_pulse;

  int tests = 0;
  int fails = 0;

  logic [31:0] pend [10];
  logic [31:0] cur  [10];

  vid_sync_gen #(.HW(HW), .FW(FW), .CW(CW), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_req(pix_req), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_out(pix_out), .underflow(underflow), .frame_pulse(frame_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = v;
    pend[a] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Sweep whole frames pixel by pixel; optionally write one register at cycle chg_at.
  task automatic sweep(input string scen, input int cycles, input int chg_at,
                       input int chg_reg, input logic [31:0] chg_val);
    int guard = 0;
    int p = 0;
    bit erun = 1'b1;
    @(negedge clk); #1;
    while (frame_pulse !== 1'b1 && guard < 200) begin
      @(negedge clk); #1;
      guard++;
    end
    chk({scen, " R9 frame start seen"}, 64'(guard < 200), 64'd1);
    for (int i = 0; i < 10; i++) cur[i] = pend[i];
    for (int n = 0; n < cycles; n++) begin
      int hper, hpw, fper, vlen, hf, hl, vf, vl, sk, h;
      bit polh, polv, rec, valid, eh, ev, ede, efp, euf;
      logic [CW-1:0] col, dat, epix;
      valid = ((n * 7) % 5) != 0;
      dat   = CW'(n * 32'h010203 + 1);
      pix_valid = valid;
      pix_data  = dat;
      if (n == chg_at) begin
        wr_en = 1'b1; wr_addr = AW'(chg_reg); wr_data = chg_val;
        pend[chg_reg] = chg_val;
      end else begin
        wr_en = 1'b0;
      end
      #1;
      hper = int'(cur[0] & 32'hFFF);
      hpw  = int'((cur[0] >> 16) & 32'hFFF);
      fper = int'(cur[1] & 32'hFFFFFF);
      vlen = int'(cur[2] & 32'hFFFFFF);
      hf   = int'(cur[3] & 32'hFFF);
      hl   = int'((cur[3] >> 16) & 32'hFFF);
      vf   = int'(cur[4] & 32'hFFFFFF);
      vl   = int'(cur[5] & 32'hFFFFFF);
      sk   = int'(cur[6] & 32'hFFFFFF);
      polh = cur[7][0];
      polv = cur[7][1];
      rec  = cur[8][31];
      col  = cur[8][CW-1:0];
      h    = (hper == 0) ? 0 : p % hper;
      eh   = (erun && h < hpw) ^ polh;
      ev   = (erun && p < vlen) ^ polv;
      ede  = erun && h >= hf && h <= hl && p >= vf + sk && p <= vl + sk;
      euf  = ede && !valid;
      epix = !ede ? '0 : (valid ? dat : (rec ? col : '0));
      efp  = erun && p == 0;
      if (erun) begin
        chk({scen, " R1 hsync"}, 64'(hsync), 64'(eh));
        chk({scen, " R2 vsync"}, 64'(vsync), 64'(ev));
      end else begin
        chk({scen, " R5 R7 idle sync levels"}, 64'({hsync, vsync}), 64'({eh, ev}));
      end
      chk({scen, " R3 R4 de/req"}, 64'({de, pix_req}), 64'({ede, ede}));
      chk({scen, " R6 pixel"}, 64'({underflow, pix_out}), 64'({euf, epix}));
      chk({scen, " R9 frame pulse"}, 64'(frame_pulse), 64'(efp));
      if (erun) begin
        if (p == fper - 1) begin
          p = 0;
          for (int i = 0; i < 10; i++) cur[i] = pend[i];
          erun = pend[9][0];
        end else begin
          p++;
        end
      end else begin
        for (int i = 0; i < 10; i++) cur[i] = pend[i];
        erun = pend[9][0];
        p = 0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    pix_valid = 1'b0; pix_data = '0;
    for (int i = 0; i < 10; i++) pend[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R10: idle state after reset
    chk("R10 reset syncs", 64'({hsync, vsync}), 64'd0);
    chk("R10 reset de/pulse", 64'({de, pix_req, frame_pulse, underflow}), 64'd0);
    chk("R10 reset pixel", 64'(pix_out), 64'd0);

    // 8-pixel lines, 2-pixel hsync, 5 lines, 1-line vsync, window 3..6 x lines 2..3
    wr(0, (32'd2 << 16) | 32'd8);
    wr(1, 32'd40);
    wr(2, 32'd8);
    wr(3, (32'd6 << 16) | 32'd3);
    wr(4, 32'd16);
    wr(5, 32'd31);
    wr(6, 32'd0);
    wr(7, 32'd0);
    wr(8, 32'h8000_00FF);
    wr(9, 32'd1);

    sweep("base", 80, -1, 0, 32'd0);
    // R4 R8: skew written mid-frame takes effect from the next frame
    sweep("skew", 80, 5, 6, 32'd8);
    // R8: hsync width change mid-frame
    sweep("width", 80, 12, 0, (32'd3 << 16) | 32'd8);
    // R6: recovery off, underflow gives black
    sweep("norec", 80, 5, 8, 32'h0000_00AA);
    // R5: both syncs active-low
    sweep("pol", 80, 5, 7, 32'd3);
    // R7: disable at pixel 10 of the second frame, then idle
    sweep("stop", 120, 50, 9, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule